// File: doc/BRIEF.md
# Flash Program/Erase Sequence Controller

This block is the control state machine between a CPU bus and a flash array split into 16-Kbyte blocks. It observes writes to a high-voltage control register and accesses to array addresses. From these it tracks where a program or erase sequence stands. It tells plain array writes apart from programming writes and erase interlock writes, and it tags every array read as normal, program-margin or erase-margin. The analog side (pulse timing, sense amplifier, bitcells) is modelled outside. The block only emits a registered one-cycle request per array operation and a read-completion strobe that carries the read type.

Control word bits: bit 0 is the sequence-run bit, bit 1 the high-voltage bit, bit 2 the mode bit (1 = erase, 0 = program), and bits 3 and up hold one block-select bit per block. The sequence machine has nine states. SQ_IDLE leads to SQ_PRG_ARM or SQ_ERS_ARM when the run bit rises. SQ_PRG_ARM moves to SQ_PRG_LOAD on the first array write. SQ_ERS_ARM moves to SQ_ERS_LOCK on the interlock write. SQ_PRG_LOAD moves to SQ_PRG_HV, and SQ_ERS_LOCK to SQ_ERS_HV, when the high-voltage bit rises. SQ_PRG_HV moves to SQ_PRG_DONE, and SQ_ERS_HV to SQ_ERS_DONE, when that bit falls. Every non-idle state returns to SQ_IDLE when the run bit is written 0. A separate read machine has two states. RD_IDLE serves page hits and moves to RD_FILL on a miss. RD_FILL always returns to RD_IDLE after one cycle.

Top module: `flash_seq_ctrl`

## Requirements
- R1: After reset: seq_active, hv_on, erase_sel and wr_err are 0, blk_sel is 0, arr_op is 0, rd_valid is 0 and bus_ready is 1.
- R2: A control write with bit 0 set while no sequence runs starts one: seq_active goes to 1, erase_sel takes bit 2 and blk_sel takes bits 3 and up. While a sequence runs, control writes never restart it and never change erase_sel or blk_sel.
- R3: hv_on rises only on a control write with bits 0 and 1 set. This works only once a program sequence has had a programming write, or an erase sequence has had its interlock write; otherwise hv_on stays 0. Once hv_on has fallen it cannot rise again in the same sequence. A control write with bit 0 clear ends the sequence: seq_active and hv_on go to 0.
- R4: In an erase sequence, the first array write produces arr_op 3 (interlock), with arr_wdata 0 whatever the bus data was. Later array writes in the same sequence produce arr_op 0.
- R5: In a program sequence, array writes before hv_on first rises produce arr_op 2 (program load) with the bus address and data. Writes after hv_on has fallen produce arr_op 0.
- R6: An array write while hv_on is 1 produces arr_op 0 and sets wr_err. wr_err stays set until the next sequence start clears it.
- R7: An array write with no sequence running produces arr_op 4 (plain write).
- R8: A read misses the page buffer when its page (address shifted right by PAGE_BITS) differs from the buffered page or the buffer is empty. On a miss, bus_ready is 0 and arr_op is 1 for one cycle, and rd_valid with rd_offpage 1 follows one cycle later. On a hit, rd_valid appears the cycle after the request, with rd_offpage 0 and no stall. A miss loads the buffer. A sequence start or end, a program load or an interlock write empties it.
- R9: rd_type is 1 for a missed read in a program sequence after its first programming write. It is 2 for a missed read in an erase sequence after its interlock write. It is 0 in every other case, including all page hits.
- R10: With every non-zero arr_op, arr_blk equals the 16-Kbyte block index of arr_addr (address bits above bit 13).
- R11: Requests made while bus_ready is 0, and control-register reads, have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_req | input | 1 | Bus access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_ctl | input | 1 | 1 = control register, 0 = array |
| bus_addr | input | ADDR_W | Array byte address |
| bus_wdata | input | DATA_W | Write data / control word |
| bus_ready | output | 1 | Low while a page fill is in progress |
| seq_active | output | 1 | Sequence running |
| hv_on | output | 1 | High-voltage phase active |
| erase_sel | output | 1 | Latched mode, 1 = erase |
| blk_sel | output | NBLK | Latched per-block select mask |
| wr_err | output | 1 | Write attempted during high voltage |
| arr_op | output | 3 | Array request: 0 none, 1 fill, 2 program load, 3 interlock, 4 plain |
| arr_addr | output | ADDR_W | Request address |
| arr_blk | output | BLK_IDX_W | Request block index |
| arr_wdata | output | DATA_W | Request data |
| rd_valid | output | 1 | Read completion strobe |
| rd_type | output | 2 | Read kind: 0 normal, 1 program margin, 2 erase margin |
| rd_offpage | output | 1 | Completed read refilled the page buffer |

## Verification
Assertions check on every cycle several properties of the machine. The high-voltage phase only rises inside a running sequence, and mode and block mask stay frozen while a sequence runs. An interlock request only follows the erase-armed state, and a program load never comes out of the high-voltage phase. A sequence start always clears the error flag, a page fill finishes in exactly one extra cycle, and margin types appear only on refilled reads. The bench's scenarios show the rest against an independent model: the exact request code for each phase, the zeroed interlock data, page hits and misses across buffer invalidation, ignored requests during a stall, and the classification of reads in each phase.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

    typedef enum logic [3:0] {
        SQ_IDLE,
        SQ_PRG_ARM,
        SQ_PRG_LOAD,
        SQ_PRG_HV,
        SQ_PRG_DONE,
        SQ_ERS_ARM,
        SQ_ERS_LOCK,
        SQ_ERS_HV,
        SQ_ERS_DONE
    } seq_state_e;

    typedef enum logic [2:0] {
        AOP_NONE  = 3'd0,
        AOP_FILL  = 3'd1,
        AOP_PROG  = 3'd2,
        AOP_LOCK  = 3'd3,
        AOP_PLAIN = 3'd4
    } arr_op_e;

    typedef enum logic [1:0] {
        RT_NORMAL  = 2'd0,
        RT_PMARGIN = 2'd1,
        RT_EMARGIN = 2'd2
    } rd_type_e;

    localparam int CTL_RUN      = 0;
    localparam int CTL_HV       = 1;
    localparam int CTL_ERASE    = 2;
    localparam int CTL_MASK_LSB = 3;

    // Margin kind of an off-page read, given the sequence phase
    function automatic rd_type_e phase_rd_type(input seq_state_e s);
        rd_type_e t;
        unique case (s)
            SQ_PRG_LOAD, SQ_PRG_HV, SQ_PRG_DONE: t = RT_PMARGIN;
            SQ_ERS_LOCK, SQ_ERS_HV, SQ_ERS_DONE: t = RT_EMARGIN;
            default:                             t = RT_NORMAL;
        endcase
        return t;
    endfunction

endpackage

// File: rtl/fsc_seq_fsm.sv
module fsc_seq_fsm
    import flash_seq_pkg::*;
#(
    parameter int ADDR_W = 17,
    parameter int DATA_W = 32,
    parameter int NBLK   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_wr,
    input  logic              arr_wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              ses_o,
    output logic              ehv_o,
    output logic              erase_o,
    output logic [NBLK-1:0]   mask_o,
    output logic              err_o,
    output arr_op_e           op_o,
    output logic [ADDR_W-1:0] op_addr_o,
    output logic [DATA_W-1:0] op_data_o,
    output rd_type_e          rd_cls_o,
    output logic              flush_o
);

    seq_state_e        state_q, state_d;
    logic              erase_q, erase_d;
    logic [NBLK-1:0]   mask_q, mask_d;
    logic              err_q, err_d;
    arr_op_e           op_q, op_d;
    logic [ADDR_W-1:0] op_addr_q;
    logic [DATA_W-1:0] op_data_q, op_data_d;
    logic              flush_d;

    // Next-state and request decode
    always_comb begin
        state_d   = state_q;
        erase_d   = erase_q;
        mask_d    = mask_q;
        err_d     = err_q;
        op_d      = AOP_NONE;
        flush_d   = 1'b0;
        if (ctl_wr) begin
            if (state_q == SQ_IDLE) begin
                if (wdata[CTL_RUN]) begin
                    erase_d = wdata[CTL_ERASE];
                    mask_d  = wdata[CTL_MASK_LSB +: NBLK];
                    err_d   = 1'b0;
                    state_d = wdata[CTL_ERASE] ? SQ_ERS_ARM : SQ_PRG_ARM;
                    flush_d = 1'b1;
                end
            end else if (!wdata[CTL_RUN]) begin
                state_d = SQ_IDLE;
                flush_d = 1'b1;
            end else begin
                unique case (state_q)
                    SQ_PRG_LOAD: if (wdata[CTL_HV])  state_d = SQ_PRG_HV;
                    SQ_ERS_LOCK: if (wdata[CTL_HV])  state_d = SQ_ERS_HV;
                    SQ_PRG_HV:   if (!wdata[CTL_HV]) state_d = SQ_PRG_DONE;
                    SQ_ERS_HV:   if (!wdata[CTL_HV]) state_d = SQ_ERS_DONE;
                    default: ;
                endcase
            end
        end else if (arr_wr) begin
            unique case (state_q)
                SQ_IDLE: op_d = AOP_PLAIN;
                SQ_PRG_ARM, SQ_PRG_LOAD: begin
                    op_d    = AOP_PROG;
                    state_d = SQ_PRG_LOAD;
                    flush_d = 1'b1;
                end
                SQ_ERS_ARM: begin
                    op_d    = AOP_LOCK;
                    state_d = SQ_ERS_LOCK;
                    flush_d = 1'b1;
                end
                SQ_PRG_HV, SQ_ERS_HV: err_d = 1'b1;
                SQ_PRG_DONE, SQ_ERS_LOCK, SQ_ERS_DONE: ;
            endcase
        end
        op_data_d = (op_d == AOP_LOCK) ? '0 : wdata;
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= SQ_IDLE;
            erase_q   <= 1'b0;
            mask_q    <= '0;
            err_q     <= 1'b0;
            op_q      <= AOP_NONE;
            op_addr_q <= '0;
            op_data_q <= '0;
        end else begin
            state_q   <= state_d;
            erase_q   <= erase_d;
            mask_q    <= mask_d;
            err_q     <= err_d;
            op_q      <= op_d;
            op_addr_q <= addr;
            op_data_q <= op_data_d;
        end
    end

    // Outputs
    always_comb begin
        ses_o     = (state_q != SQ_IDLE);
        ehv_o     = (state_q == SQ_PRG_HV) || (state_q == SQ_ERS_HV);
        erase_o   = erase_q;
        mask_o    = mask_q;
        err_o     = err_q;
        op_o      = op_q;
        op_addr_o = op_addr_q;
        op_data_o = op_data_q;
        rd_cls_o  = phase_rd_type(state_q);
        flush_o   = flush_d;
    end

    p_hv_inside_seq_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ehv_o) |-> $past(ses_o));

    p_cfg_frozen_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ses_o && $past(ses_o)) |-> ($stable(erase_q) && $stable(mask_q)));

    p_lock_from_arm_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (op_q == AOP_LOCK) |-> ($past(state_q) == SQ_ERS_ARM));

    p_no_load_in_hv_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (op_q == AOP_PROG) |-> !$past(ehv_o));

    p_start_clears_err_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ses_o) |-> !err_q);

endmodule

// File: rtl/fsc_rd_path.sv
module fsc_rd_path
    import flash_seq_pkg::*;
#(
    parameter int ADDR_W    = 17,
    parameter int PAGE_BITS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_req,
    input  logic [ADDR_W-1:0] rd_addr,
    input  rd_type_e          rd_cls,
    input  logic              flush,
    output logic              ready_o,
    output logic              filling_o,
    output logic [ADDR_W-1:0] fill_addr_o,
    output logic              rd_valid_o,
    output rd_type_e          rd_type_o,
    output logic              rd_off_o
);

    localparam int TAG_W = ADDR_W - PAGE_BITS;

    typedef enum logic {RD_IDLE, RD_FILL} rd_state_e;

    rd_state_e         st_q;
    logic [TAG_W-1:0]  tag_q;
    logic              tag_vld_q;
    rd_type_e          pend_q;
    logic [ADDR_W-1:0] fill_addr_q;
    logic              rd_valid_q;
    rd_type_e          rd_type_q;
    logic              rd_off_q;
    logic              hit;

    assign hit = tag_vld_q && (rd_addr[ADDR_W-1:PAGE_BITS] == tag_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q        <= RD_IDLE;
            tag_q       <= '0;
            tag_vld_q   <= 1'b0;
            pend_q      <= RT_NORMAL;
            fill_addr_q <= '0;
            rd_valid_q  <= 1'b0;
            rd_type_q   <= RT_NORMAL;
            rd_off_q    <= 1'b0;
        end else begin
            rd_valid_q <= 1'b0;
            unique case (st_q)
                RD_IDLE: begin
                    if (flush) tag_vld_q <= 1'b0;
                    if (rd_req) begin
                        if (hit) begin
                            rd_valid_q <= 1'b1;
                            rd_type_q  <= RT_NORMAL;
                            rd_off_q   <= 1'b0;
                        end else begin
                            st_q        <= RD_FILL;
                            pend_q      <= rd_cls;
                            fill_addr_q <= rd_addr;
                        end
                    end
                end
                RD_FILL: begin
                    st_q       <= RD_IDLE;
                    rd_valid_q <= 1'b1;
                    rd_type_q  <= pend_q;
                    rd_off_q   <= 1'b1;
                    tag_q      <= fill_addr_q[ADDR_W-1:PAGE_BITS];
                    tag_vld_q  <= 1'b1;
                end
            endcase
        end
    end

    always_comb begin
        ready_o     = (st_q == RD_IDLE);
        filling_o   = (st_q == RD_FILL);
        fill_addr_o = fill_addr_q;
        rd_valid_o  = rd_valid_q;
        rd_type_o   = rd_type_q;
        rd_off_o    = rd_off_q;
    end

    p_fill_two_clocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == RD_FILL) |=> (st_q == RD_IDLE && rd_valid_q && rd_off_q));

    p_hit_is_normal_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid_q && !rd_off_q) |-> (rd_type_q == RT_NORMAL));

endmodule

// File: rtl/flash_seq_ctrl.sv
module flash_seq_ctrl
    import flash_seq_pkg::*;
#(
    parameter int ADDR_W    = 17,
    parameter int DATA_W    = 32,
    parameter int BLK_SHIFT = 14,
    parameter int PAGE_BITS = 4,
    localparam int BLK_IDX_W = ADDR_W - BLK_SHIFT,
    localparam int NBLK      = 1 << BLK_IDX_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_req,
    input  logic                 bus_we,
    input  logic                 bus_ctl,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic                 bus_ready,
    output logic                 seq_active,
    output logic                 hv_on,
    output logic                 erase_sel,
    output logic [NBLK-1:0]      blk_sel,
    output logic                 wr_err,
    output logic [2:0]           arr_op,
    output logic [ADDR_W-1:0]    arr_addr,
    output logic [BLK_IDX_W-1:0] arr_blk,
    output logic [DATA_W-1:0]    arr_wdata,
    output logic                 rd_valid,
    output logic [1:0]           rd_type,
    output logic                 rd_offpage
);

    logic              acc, ctl_wr, arr_wr, arr_rd;
    logic              flush, filling;
    arr_op_e           fsm_op;
    logic [ADDR_W-1:0] fsm_addr, fill_addr;
    logic [DATA_W-1:0] fsm_data;
    rd_type_e          rd_cls, rd_type_e_w;

    assign acc    = bus_req && bus_ready;
    assign ctl_wr = acc && bus_we && bus_ctl;
    assign arr_wr = acc && bus_we && !bus_ctl;
    assign arr_rd = acc && !bus_we && !bus_ctl;

    fsc_seq_fsm #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .NBLK   (NBLK)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl_wr    (ctl_wr),
        .arr_wr    (arr_wr),
        .addr      (bus_addr),
        .wdata     (bus_wdata),
        .ses_o     (seq_active),
        .ehv_o     (hv_on),
        .erase_o   (erase_sel),
        .mask_o    (blk_sel),
        .err_o     (wr_err),
        .op_o      (fsm_op),
        .op_addr_o (fsm_addr),
        .op_data_o (fsm_data),
        .rd_cls_o  (rd_cls),
        .flush_o   (flush)
    );

    fsc_rd_path #(
        .ADDR_W    (ADDR_W),
        .PAGE_BITS (PAGE_BITS)
    ) u_rd (
        .clk         (clk),
        .rst_n       (rst_n),
        .rd_req      (arr_rd),
        .rd_addr     (bus_addr),
        .rd_cls      (rd_cls),
        .flush       (flush),
        .ready_o     (bus_ready),
        .filling_o   (filling),
        .fill_addr_o (fill_addr),
        .rd_valid_o  (rd_valid),
        .rd_type_o   (rd_type_e_w),
        .rd_off_o    (rd_offpage)
    );

    always_comb begin
        arr_op    = filling ? AOP_FILL : fsm_op;
        arr_addr  = filling ? fill_addr : fsm_addr;
        arr_wdata = filling ? '0 : fsm_data;
        arr_blk   = arr_addr[ADDR_W-1:BLK_SHIFT];
        rd_type   = rd_type_e_w;
    end

    p_stall_no_write_op_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_ready) |=> (fsm_op == AOP_NONE));

endmodule

// File: tb/flash_seq_ctrl_tb.sv
`timescale 1ns/1ps
module flash_seq_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_req = 1'b0, bus_we = 1'b0, bus_ctl = 1'b0;
    logic [16:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_ready, seq_active, hv_on, erase_sel, wr_err;
    logic [7:0]  blk_sel;
    logic [2:0]  arr_op;
    logic [16:0] arr_addr;
    logic [2:0]  arr_blk;
    logic [31:0] arr_wdata;
    logic        rd_valid, rd_offpage;
    logic [1:0]  rd_type;

    int n_chk = 0, n_fail = 0;

    // model state: phase 0 idle, 1 armed, 2 loaded/locked, 3 high voltage, 4 done
    int          m_ph = 0;
    bit          m_erase = 0, m_err = 0, m_tagv = 0;
    logic [7:0]  m_mask = '0;
    logic [12:0] m_tag = '0;

    flash_seq_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
        .bus_ctl(bus_ctl), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_ready(bus_ready), .seq_active(seq_active), .hv_on(hv_on),
        .erase_sel(erase_sel), .blk_sel(blk_sel), .wr_err(wr_err),
        .arr_op(arr_op), .arr_addr(arr_addr), .arr_blk(arr_blk),
        .arr_wdata(arr_wdata), .rd_valid(rd_valid), .rd_type(rd_type),
        .rd_offpage(rd_offpage)
    );

    always #4 clk = ~clk;

    task automatic chk(input string rq, input string what, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    function automatic int exp_rd_type(input bit off);
        if (!off || m_ph < 2) return 0;
        return m_erase ? 2 : 1;
    endfunction

    task automatic do_ctl(input logic [31:0] d);
        @(negedge clk);
        bus_req = 1; bus_we = 1; bus_ctl = 1; bus_wdata = d;
        @(negedge clk);
        bus_req = 0;
        if (m_ph == 0) begin
            if (d[0]) begin
                m_ph = 1; m_erase = d[2]; m_mask = d[10:3]; m_err = 0; m_tagv = 0;
            end
        end else if (!d[0]) begin
            m_ph = 0; m_tagv = 0;
        end else if (d[1] && m_ph == 2) m_ph = 3;
        else if (!d[1] && m_ph == 3) m_ph = 4;
        chk("R2", "seq_active", seq_active, m_ph != 0);
        chk("R3", "hv_on", hv_on, m_ph == 3);
        chk("R2", "erase_sel", erase_sel, m_erase);
        chk("R2", "blk_sel", blk_sel, m_mask);
        chk("R6", "wr_err", wr_err, m_err);
        chk("R11", "arr_op after ctl", arr_op, 0);
    endtask

    task automatic do_wr(input logic [16:0] a, input logic [31:0] d);
        int eop; logic [31:0] ed; string rq;
        @(negedge clk);
        bus_req = 1; bus_we = 1; bus_ctl = 0; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_req = 0;
        eop = 0; ed = d; rq = "R5";
        if (m_ph == 0) begin eop = 4; rq = "R7"; end
        else if (m_erase) begin
            rq = "R4";
            if (m_ph == 1) begin eop = 3; ed = 0; m_ph = 2; m_tagv = 0; end
            else if (m_ph == 3) begin m_err = 1; rq = "R6"; end
        end else begin
            if (m_ph == 1 || m_ph == 2) begin eop = 2; m_ph = 2; m_tagv = 0; end
            else if (m_ph == 3) begin m_err = 1; rq = "R6"; end
        end
        chk(rq, "arr_op", arr_op, eop);
        if (eop != 0) begin
            chk(rq, "arr_addr", arr_addr, a);
            chk(rq, "arr_wdata", arr_wdata, ed);
            chk("R10", "arr_blk", arr_blk, a >> 14);
        end
        chk("R6", "wr_err", wr_err, m_err);
    endtask

    task automatic do_rd(input logic [16:0] a);
        bit off;
        @(negedge clk);
        bus_req = 1; bus_we = 0; bus_ctl = 0; bus_addr = a;
        @(negedge clk);
        bus_req = 0;
        off = !(m_tagv && (a[16:4] == m_tag));
        if (off) begin
            chk("R8", "ready during fill", bus_ready, 0);
            chk("R8", "arr_op fill", arr_op, 1);
            chk("R10", "fill blk", arr_blk, a >> 14);
            chk("R8", "early valid", rd_valid, 0);
            @(negedge clk);
        end else begin
            chk("R8", "ready on hit", bus_ready, 1);
        end
        chk("R8", "rd_valid", rd_valid, 1);
        chk("R8", "rd_offpage", rd_offpage, off);
        chk("R9", "rd_type", rd_type, exp_rd_type(off));
        if (off) begin m_tag = a[16:4]; m_tagv = 1; end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        void'($urandom(32'h5EED_F1A5));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1", "seq_active", seq_active, 0);
        chk("R1", "hv_on", hv_on, 0);
        chk("R1", "erase_sel", erase_sel, 0);
        chk("R1", "blk_sel", blk_sel, 0);
        chk("R1", "wr_err", wr_err, 0);
        chk("R1", "arr_op", arr_op, 0);
        chk("R1", "rd_valid", rd_valid, 0);
        chk("R1", "bus_ready", bus_ready, 1);

        do_wr(17'h04010, 32'h1111_2222);             // R7 plain
        do_rd(17'h00020); do_rd(17'h00024);          // R8 miss then hit
        do_ctl(32'h1 | (32'h05 << 3));               // start program
        do_rd(17'h00020);                            // R9 armed: normal, flushed
        do_ctl(32'h1 | 32'h4 | (32'hFF << 3));       // R2 change ignored
        do_ctl(32'h3);                               // R3 EHV in armed ignored
        do_wr(17'h08000, 32'hA5A5_0001);             // R5 load
        do_wr(17'h08004, 32'hA5A5_0002);
        do_rd(17'h08000); do_rd(17'h08008);          // R9 program margin, then hit
        do_ctl(32'h3);                               // HV on
        do_wr(17'h08010, 32'h0);                     // R6 error
        do_ctl(32'h1);                               // HV off
        do_ctl(32'h3);                               // R3 no second pulse
        do_wr(17'h08010, 32'h5);                     // R5 ignored after HV
        do_rd(17'h0C000);
        do_ctl(32'h0);                               // end
        do_rd(17'h0C000);                            // R9 normal again
        do_ctl(32'h1 | 32'h4 | (32'h12 << 3));       // erase start, R6 err cleared
        do_wr(17'h14000, 32'hDEAD_BEEF);             // R4 interlock, data 0
        do_wr(17'h14004, 32'h1234_5678);             // R4 ignored
        do_rd(17'h14000);                            // R9 erase margin
        do_ctl(32'h3); do_ctl(32'h1); do_ctl(32'h0);

        // R11: request held during a fill is dropped
        @(negedge clk);
        bus_req = 1; bus_we = 0; bus_ctl = 0; bus_addr = 17'h1C000;
        @(negedge clk);
        chk("R11", "stall", bus_ready, 0);
        bus_we = 1; bus_ctl = 1; bus_wdata = 32'h1;
        @(negedge clk);
        bus_req = 0;
        chk("R11", "rd_valid", rd_valid, 1);
        m_tag = 13'h1C00; m_tagv = 1;
        @(negedge clk);
        chk("R11", "seq_active", seq_active, 0);
        // R11: control read ignored
        bus_req = 1; bus_we = 0; bus_ctl = 1;
        @(negedge clk);
        bus_req = 0;
        chk("R11", "ctl read op", arr_op, 0);
        chk("R11", "ctl read valid", rd_valid, 0);

        for (int i = 0; i < 600; i++) begin
            int k;
            logic [16:0] a;
            logic [31:0] d;
            k = $urandom_range(0, 99);
            a = 17'(($urandom_range(0, 7) << 14) | ($urandom_range(0, 3) << 4) | $urandom_range(0, 15));
            if (k < 30) begin
                d = {21'h0, 8'($urandom), 1'($urandom), 1'($urandom), 1'($urandom_range(0, 3) != 0)};
                do_ctl(d);
            end else if (k < 65) do_wr(a, $urandom);
            else do_rd(a);
        end
        finish_run();
    end

endmodule